// File: doc/BRIEF.md
# Active-Part Search Key Extractor

This block prepares the search key for a compacted-trie route lookup. It takes a W-bit destination address and looks at its top bit. If the top bit is 0, the address begins with a run of zeros that ends at the first 1. If the top bit is 1, it begins with a run of ones that ends at the first 0. The block finds the bit that ends this leading run and removes the run and that bit with a left barrel shift. The bits that remain, packed at the top of the word, form the active-part key. The block also reports the run length plus one, the top bit, the number of active bits left, and the positions of the lowest set bit and the lowest clear bit. A trie walk downstream uses these values to compare against the leading-run and trailing-run fields stored with each prefix, and to stop once the last active bit has been used.

An address is offered with `in_valid`. The results appear one clock later with `out_valid`, and a new address can be taken every cycle. An address that is all zeros or all ones has no bit that ends the run. For such an address the block raises `out_nokey` and clears the key and the lengths.

Top module: `ap_key_extractor`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` at 1, so back-to-back addresses give back-to-back results.
- R3: `out_msb` equals bit W-1 of the accepted address.
- R4: Bit positions are indexed from the top, with bit W-1 as index 0. For an address whose top bit is 0, `out_mlen` is the index of the highest 1 plus one.
- R5: For an address whose top bit is 1, `out_mlen` is the index of the highest 0 plus one.
- R6: `out_key` equals the accepted address shifted left by `out_mlen` places, with zeros filling from the bottom. A shift of W gives zero.
- R7: When `out_nokey` is 0, `out_aplen` equals W minus `out_mlen`.
- R8: `out_lsset` is the top-based index of the lowest 1 in the address, or 0 if the address has no 1.
- R9: `out_lsclr` is the top-based index of the lowest 0 in the address, or 0 if the address has no 0.
- R10: For an all-zeros or all-ones address, `out_nokey` is 1 and `out_mlen`, `out_aplen` and `out_key` are all 0. Otherwise `out_nokey` is 0.
- R11: A cycle with `in_valid` at 0 leaves every data output unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address on `in_addr` is offered |
| in_addr | input | W | Destination address |
| out_valid | output | 1 | Outputs hold a result |
| out_key | output | W | Active-part key, packed at the top |
| out_mlen | output | clog2(W)+1 | Leading-run length plus one |
| out_msb | output | 1 | Top bit of the address |
| out_aplen | output | clog2(W)+1 | Number of active key bits |
| out_lsset | output | clog2(W) | Top-based index of the lowest 1 |
| out_lsclr | output | clog2(W) | Top-based index of the lowest 0 |
| out_nokey | output | 1 | Address has no bit ending the leading run |

## Verification
The properties assume that `in_addr` carries a known value in every cycle where `in_valid` is 1. They also assume that `in_valid` itself is never unknown after reset. The bench meets both conditions. It drives every input only on falling edges and gives `in_addr` a defined pattern even in idle cycles. The patterns it uses are all zeros, all ones, single set and single clear bits at every position, alternating bits, and random words. It also inserts idle gaps so the hold rule is exercised.

// File: rtl/apk_pkg.sv
package apk_pkg;
    // How the leading run of an address is formed.
    typedef enum logic {
        RUN_ZEROS = 1'b0,
        RUN_ONES  = 1'b1
    } run_kind_e;
endpackage

// File: rtl/apk_lead_find.sv
// Finds the top-based index of the highest 1 in v.
module apk_lead_find #(
    parameter int W  = 32,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  v,
    output logic [PW-1:0] pos,
    output logic          found
);
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[W-1-i]) pos = PW'(i);
        end
    end
    assign found = |v;
endmodule

// File: rtl/apk_trail_find.sv
// Finds the top-based index of the lowest 1 in v (0 if none).
module apk_trail_find #(
    parameter int W  = 32,
    parameter int PW = $clog2(W)
) (
    input  logic [W-1:0]  v,
    output logic [PW-1:0] pos
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (v[W-1-i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/apk_barrel.sv
// Logarithmic left shifter; shift amounts of W or more give zero.
module apk_barrel #(
    parameter int W  = 32,
    parameter int SW = $clog2(W) + 1
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [0:SW];
    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        if ((1 << k) < W) begin : g_shift
            assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
        end else begin : g_clear
            assign stage[k+1] = amt[k] ? '0 : stage[k];
        end
    end

    assign dout = stage[SW];
endmodule

// File: rtl/ap_key_extractor.sv
module ap_key_extractor #(
    parameter int W  = 32,
    localparam int PW = $clog2(W),
    localparam int LW = $clog2(W) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [W-1:0]  in_addr,
    output logic          out_valid,
    output logic [W-1:0]  out_key,
    output logic [LW-1:0] out_mlen,
    output logic          out_msb,
    output logic [LW-1:0] out_aplen,
    output logic [PW-1:0] out_lsset,
    output logic [PW-1:0] out_lsclr,
    output logic          out_nokey
);
    import apk_pkg::*;

    run_kind_e     kind;
    logic [W-1:0]  norm;
    logic [PW-1:0] term_pos;
    logic          term_found;
    logic [PW-1:0] lsset_c;
    logic [PW-1:0] lsclr_c;
    logic [LW-1:0] mlen_c;
    logic [LW-1:0] aplen_c;
    logic [W-1:0]  shifted;
    logic [W-1:0]  key_c;

    assign kind = run_kind_e'(in_addr[W-1]);
    // Normalise so the terminating bit is always the highest 1.
    assign norm = (kind == RUN_ONES) ? ~in_addr : in_addr;

    apk_lead_find #(.W(W), .PW(PW)) u_lead (
        .v     (norm),
        .pos   (term_pos),
        .found (term_found)
    );

    apk_trail_find #(.W(W), .PW(PW)) u_lsset (
        .v   (in_addr),
        .pos (lsset_c)
    );

    apk_trail_find #(.W(W), .PW(PW)) u_lsclr (
        .v   (~in_addr),
        .pos (lsclr_c)
    );

    always_comb begin
        if (term_found) begin
            mlen_c  = LW'(term_pos) + LW'(1);
            aplen_c = LW'(W) - mlen_c;
        end else begin
            mlen_c  = '0;
            aplen_c = '0;
        end
    end

    apk_barrel #(.W(W), .SW(LW)) u_shift (
        .din  (in_addr),
        .amt  (mlen_c),
        .dout (shifted)
    );

    assign key_c = term_found ? shifted : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_key   <= '0;
            out_mlen  <= '0;
            out_msb   <= 1'b0;
            out_aplen <= '0;
            out_lsset <= '0;
            out_lsclr <= '0;
            out_nokey <= 1'b0;
        end else if (in_valid) begin
            out_key   <= key_c;
            out_mlen  <= mlen_c;
            out_msb   <= in_addr[W-1];
            out_aplen <= aplen_c;
            out_lsset <= lsset_c;
            out_lsclr <= lsclr_c;
            out_nokey <= ~term_found;
        end
    end
endmodule

// File: rtl/apk_checker.sv
module apk_checker #(
    parameter int W  = 32,
    localparam int PW = $clog2(W),
    localparam int LW = $clog2(W) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [W-1:0]  in_addr,
    input logic          out_valid,
    input logic [W-1:0]  out_key,
    input logic [LW-1:0] out_mlen,
    input logic          out_msb,
    input logic [LW-1:0] out_aplen,
    input logic [PW-1:0] out_lsset,
    input logic [PW-1:0] out_lsclr,
    input logic          out_nokey
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_follows_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3
    msb_capture_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_msb == $past(in_addr[W-1])));

    // R7
    length_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_nokey) |-> ((out_aplen + out_mlen) == LW'(W)));

    // R10
    nokey_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nokey) |-> (out_mlen == '0 && out_aplen == '0 && out_key == '0));

    // R11
    hold_key_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_key) && $stable(out_mlen) && $stable(out_lsset)
                       && $stable(out_lsclr) && $stable(out_nokey)));
endmodule

bind ap_key_extractor apk_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_key   (out_key),
    .out_mlen  (out_mlen),
    .out_msb   (out_msb),
    .out_aplen (out_aplen),
    .out_lsset (out_lsset),
    .out_lsclr (out_lsclr),
    .out_nokey (out_nokey)
);

// File: tb/ap_key_extractor_tb.sv
module ap_key_extractor_tb;
    localparam int W  = 32;
    localparam int PW = $clog2(W);
    localparam int LW = $clog2(W) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_addr = '0;
    logic          out_valid;
    logic [W-1:0]  out_key;
    logic [LW-1:0] out_mlen;
    logic          out_msb;
    logic [LW-1:0] out_aplen;
    logic [PW-1:0] out_lsset;
    logic [PW-1:0] out_lsclr;
    logic          out_nokey;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ap_key_extractor #(.W(W)) u_dut (
        .clk, .rst, .in_valid, .in_addr, .out_valid, .out_key, .out_mlen,
        .out_msb, .out_aplen, .out_lsset, .out_lsclr, .out_nokey
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected values from the requirements.
    task automatic expect_all(input logic [W-1:0] a);
        int  term = -1;
        int  lset = 0;
        int  lclr = 0;
        int  mlen;
        logic [W-1:0] key;
        bit  top = a[W-1];
        for (int i = 0; i < W; i++) begin
            if (term < 0 && a[W-1-i] != top) term = i;
            if (a[W-1-i]) lset = i;
            if (!a[W-1-i]) lclr = i;
        end
        mlen = (term < 0) ? 0 : term + 1;
        key  = (term < 0 || mlen >= W) ? '0 : (a << mlen);
        check("R2", "out_valid", out_valid, 1);
        check("R3", "out_msb", out_msb, top);
        check(top ? "R5" : "R4", "out_mlen", out_mlen, mlen);
        check("R6", "out_key", out_key, key);
        check("R7", "out_aplen", out_aplen, (term < 0) ? 0 : W - mlen);
        check("R8", "out_lsset", out_lsset, lset);
        check("R9", "out_lsclr", out_lsclr, lclr);
        check("R10", "out_nokey", out_nokey, (term < 0) ? 1 : 0);
    endtask

    task automatic send(input logic [W-1:0] a);
        in_valid = 1'b1;
        in_addr  = a;
        @(negedge clk);
        expect_all(a);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_addr  = '0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after reset", out_valid, 0);
    endtask

    task automatic test_no_key();
        send('0);
        send('1);
        idle();
        @(negedge clk);
        check("R2", "out_valid idle", out_valid, 0);
    endtask

    task automatic test_single_bits();
        for (int j = 0; j < W; j++) send(W'(1) << j);
        for (int j = 0; j < W; j++) send(~(W'(1) << j));
        idle();
        @(negedge clk);
    endtask

    task automatic test_alternating();
        send({(W/2){2'b01}});
        send({(W/2){2'b10}});
        send({(W/4){4'b0011}});
        send({(W/4){4'b1100}});
        // Example byte at the top: highest 1 at index 2, lowest 1 at 7.
        send({8'b0011_0101, {(W-8){1'b0}}});
        idle();
        @(negedge clk);
    endtask

    task automatic test_hold();
        logic [W-1:0]  k;
        logic [LW-1:0] m;
        logic [PW-1:0] s;
        send(32'h0123_4567);
        k = out_key; m = out_mlen; s = out_lsset;
        idle();
        in_addr = 32'hFFF0_000F;
        @(negedge clk);
        check("R11", "out_key held", out_key, k);
        check("R11", "out_mlen held", out_mlen, m);
        check("R11", "out_lsset held", out_lsset, s);
        check("R2", "out_valid low", out_valid, 0);
        in_addr = '0;
    endtask

    task automatic test_random();
        for (int n = 0; n < 200; n++) begin
            send(W'($urandom));
            if (n % 17 == 0) begin
                idle();
                @(negedge clk);
            end
        end
        idle();
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        test_no_key();
        test_single_bits();
        test_alternating();
        test_hold();
        test_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule